// File: doc/BRIEF.md
# Interrupt Request Flags with One-Step Deferral

This block keeps the request flags for five interrupt sources together with an enable mask, and gives a CPU core the vector of interrupts that are both raised and enabled. A source can raise its request at once, or it can mark the request as deferred. A deferred request first goes into a separate holding set. It moves into the stored flags only when the step that owns that source comes around. Display sources 0 and 1 are owned by the display step, source 2 by the timer step, and every source by the CPU dispatch step.

Deferred requests appear in the value the CPU reads back. While the CPU is running they also count toward the pending vector. While the CPU is halted they do not count. A CPU write to the flag register replaces the stored flags and throws away every deferred request held at that moment. The block also keeps the halted state. A halt request sets it, and any nonzero pending vector clears it.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag readback is 0xE0, the pending vector is 0 and halted is 0. The enable mask and the deferred set are both empty.
- R2: The pending vector (bit i = source i) equals enable AND stored flags over the low five bits. Enable writes keep only bits 4..0, and immediate requests set their flag bit on the next clock edge.
- R3: Readback bits 7..5 always read 1, and bits 4..0 read the stored flags ORed with the deferred set. A deferred request therefore shows on the cycle after it is raised.
- R4: A deferred request stays in the deferred set until its own merge step, and only a later step can merge it. The display step merges sources 0 and 1, and the timer step merges source 2. Neither of these steps merges sources 3 or 4.
- R5: A CPU dispatch step moves all deferred requests into the stored flags and empties the deferred set.
- R6: A CPU flag write loads bits 4..0 of the written byte and discards all deferred requests already held. A deferred request raised in the same cycle as the write is still kept.
- R7: While not halted, enabled deferred requests count toward the pending vector. While halted, they do not count.
- R8: A halt request sets halted on the next edge. A nonzero pending vector clears halted on the next edge, and it wins over a halt request raised in the same cycle.
- R9: An immediate request in the same cycle as a CPU flag write leaves its flag bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_now | input | 5 | Immediate requests, one bit per source |
| req_defer | input | 5 | Deferred requests, one bit per source |
| disp_step | input | 1 | Display step strobe |
| timer_step | input | 1 | Timer step strobe |
| cpu_step | input | 1 | CPU dispatch step strobe |
| flag_wr | input | 1 | CPU write strobe for the flag register |
| flag_wdata | input | 8 | CPU write data for the flag register |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Write data for the enable register |
| halt_req | input | 1 | Request to enter the halted state |
| flag_rdata | output | 8 | Flag readback |
| pending | output | 5 | Enabled pending interrupt vector |
| halted | output | 1 | Halted state |

## Verification
All state sits in registers that update on the rising edge. Readback and pending therefore reflect a stimulus one edge after the bench applies it. Halted reacts to a new pending vector one edge later still, so it settles two edges after the request that raised that vector.

The bench applies each stimulus on the falling edge and queues the values expected right after the following rising edge. The monitor compares them 2 ns after that edge. The wake-up checks queue one extra idle step, so that halted is compared in its own cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // Step strobes that decide when deferred requests are merged.
   typedef struct packed {
      logic disp;
      logic timer;
      logic cpu;
   } irq_step_t;

   localparam int unsigned IRQ_SRC_DEFAULT  = 5;
   localparam int unsigned IRQ_BYTE_DEFAULT = 8;
endpackage

// File: rtl/irq_defer_set.sv
module irq_defer_set
   import irq_pkg::*;
#(
   parameter int unsigned NUM_SRC    = IRQ_SRC_DEFAULT,
   parameter int unsigned DISP_MASK  = 3,
   parameter int unsigned TIMER_MASK = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  irq_step_t          step,
   input  logic               cpu_wr,
   input  logic [NUM_SRC-1:0] req_defer,
   output logic [NUM_SRC-1:0] defer_q,
   output logic [NUM_SRC-1:0] merge_out
);
   logic [NUM_SRC-1:0] merge_sel;

   if ((DISP_MASK & TIMER_MASK) != 0) begin : g_chk_overlap
      $error("irq_defer_set: a source cannot belong to both step domains");
   end
   if (NUM_SRC < 32) begin : g_chk_range
      if ((DISP_MASK >> NUM_SRC) != 0 || (TIMER_MASK >> NUM_SRC) != 0) begin : g_bad
         $error("irq_defer_set: domain mask exceeds source count");
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam bit IN_DISP  = ((DISP_MASK  >> i) & 1) != 0;
      localparam bit IN_TIMER = ((TIMER_MASK >> i) & 1) != 0;
      if (IN_DISP) begin : g_disp
         assign merge_sel[i] = step.cpu | step.disp;
      end else if (IN_TIMER) begin : g_timer
         assign merge_sel[i] = step.cpu | step.timer;
      end else begin : g_cpu_only
         assign merge_sel[i] = step.cpu;
      end
   end

   // Held bits leave only through their own merge step; a CPU write discards them.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         defer_q <= '0;
      end else if (cpu_wr) begin
         defer_q <= req_defer;
      end else begin
         defer_q <= (defer_q & ~merge_sel) | req_defer;
      end
   end

   assign merge_out = cpu_wr ? '0 : (defer_q & merge_sel);

   p_wr_discards_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && req_defer == '0) |=> (defer_q == '0));

   p_cpu_merges_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step.cpu && !cpu_wr && req_defer == '0) |=> (defer_q == '0));

   p_hold_until_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_wr && !step.cpu && !step.disp && !step.timer) |=>
         ((defer_q & $past(defer_q)) == $past(defer_q)));
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
   import irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = IRQ_SRC_DEFAULT,
   parameter int unsigned DATA_W  = IRQ_BYTE_DEFAULT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_wr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] req_now,
   input  logic [NUM_SRC-1:0] merge_in,
   output logic [NUM_SRC-1:0] flag_q
);
   logic [NUM_SRC-1:0] flag_d;

   if (NUM_SRC > DATA_W) begin : g_chk_width
      $error("irq_flag_reg: more sources than data bits");
   end

   // An immediate request is ORed in last, so it survives a CPU write.
   always_comb begin
      if (cpu_wr) begin
         flag_d = wdata[NUM_SRC-1:0] | req_now;
      end else begin
         flag_d = flag_q | merge_in | req_now;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= '0;
      end else begin
         flag_q <= flag_d;
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
      p_req_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
         req_now[i] |=> flag_q[i]);
   end
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_req,
   input  logic wake,
   output logic halted_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
      end else if (wake) begin
         halted_q <= 1'b0;
      end else if (halt_req) begin
         halted_q <= 1'b1;
      end
   end

   p_wake_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !halted_q);

   p_halt_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req && !wake) |=> halted_q);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned NUM_SRC    = IRQ_SRC_DEFAULT,
   parameter int unsigned DATA_W     = IRQ_BYTE_DEFAULT,
   parameter int unsigned DISP_MASK  = 3,
   parameter int unsigned TIMER_MASK = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_now,
   input  logic [NUM_SRC-1:0] req_defer,
   input  logic               disp_step,
   input  logic               timer_step,
   input  logic               cpu_step,
   input  logic               flag_wr,
   input  logic [DATA_W-1:0]  flag_wdata,
   input  logic               en_wr,
   input  logic [DATA_W-1:0]  en_wdata,
   input  logic               halt_req,
   output logic [DATA_W-1:0]  flag_rdata,
   output logic [NUM_SRC-1:0] pending,
   output logic               halted
);
   localparam int unsigned PAD_W = DATA_W - NUM_SRC;

   irq_step_t          step;
   logic [NUM_SRC-1:0] defer_q;
   logic [NUM_SRC-1:0] merge_bits;
   logic [NUM_SRC-1:0] flag_q;
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] defer_seen;
   logic [NUM_SRC-1:0] raw_view;

   assign step = '{disp: disp_step, timer: timer_step, cpu: cpu_step};

   irq_defer_set #(
      .NUM_SRC(NUM_SRC), .DISP_MASK(DISP_MASK), .TIMER_MASK(TIMER_MASK)
   ) u_defer (
      .clk(clk), .rst_n(rst_n), .step(step), .cpu_wr(flag_wr),
      .req_defer(req_defer), .defer_q(defer_q), .merge_out(merge_bits)
   );

   irq_flag_reg #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_flag (
      .clk(clk), .rst_n(rst_n), .cpu_wr(flag_wr), .wdata(flag_wdata),
      .req_now(req_now), .merge_in(merge_bits), .flag_q(flag_q)
   );

   irq_halt_ctrl u_halt (
      .clk(clk), .rst_n(rst_n), .halt_req(halt_req),
      .wake(|pending), .halted_q(halted)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (en_wr) begin
         en_q <= en_wdata[NUM_SRC-1:0];
      end
   end

   // Deferred requests reach dispatch only while the core runs.
   assign defer_seen = halted ? '0 : defer_q;
   assign pending    = en_q & (flag_q | defer_seen);
   assign raw_view   = flag_q | defer_q;

   if (PAD_W > 0) begin : g_padded
      assign flag_rdata = {{PAD_W{1'b1}}, raw_view};
   end else begin : g_exact
      assign flag_rdata = raw_view;
   end

   p_halt_hides_defer_r7: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> ((pending & ~flag_q) == '0));

   p_run_sees_defer_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && (en_q & defer_q) != '0) |-> (pending != '0));

   p_rdata_covers_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_rdata[NUM_SRC-1:0] & defer_q) == defer_q));
endmodule

// File: tb/tb_irq_flag_ctrl.sv
`timescale 1ns/1ps
module tb_irq_flag_ctrl;
   typedef struct {
      string      tag;
      logic [7:0] rd;
      logic [4:0] pend;
      logic       halt;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] req_now = '0, req_defer = '0;
   logic       disp_step = 0, timer_step = 0, cpu_step = 0;
   logic       flag_wr = 0, en_wr = 0, halt_req = 0;
   logic [7:0] flag_wdata = '0, en_wdata = '0;
   logic [7:0] flag_rdata;
   logic [4:0] pending;
   logic       halted;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 0;

   always #5 clk = ~clk;

   irq_flag_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_now(req_now), .req_defer(req_defer),
      .disp_step(disp_step), .timer_step(timer_step), .cpu_step(cpu_step),
      .flag_wr(flag_wr), .flag_wdata(flag_wdata), .en_wr(en_wr),
      .en_wdata(en_wdata), .halt_req(halt_req), .flag_rdata(flag_rdata),
      .pending(pending), .halted(halted)
   );

   // Driver: apply one step on the falling edge and queue what must follow the next rise.
   task automatic drive(input string tag, input logic [7:0] e_rd, input logic [4:0] e_pend,
                        input logic e_halt, input logic [4:0] now, input logic [4:0] dfr,
                        input logic [2:0] steps, input logic fwr, input logic [7:0] fdat,
                        input logic ewr, input logic [7:0] edat, input logic hlt);
      exp_t e;
      @(negedge clk);
      req_now    = now;
      req_defer  = dfr;
      disp_step  = steps[2];
      timer_step = steps[1];
      cpu_step   = steps[0];
      flag_wr    = fwr;
      flag_wdata = fdat;
      en_wr      = ewr;
      en_wdata   = edat;
      halt_req   = hlt;
      e.tag = tag; e.rd = e_rd; e.pend = e_pend; e.halt = e_halt;
      exp_q.push_back(e);
   endtask

   task automatic check_one(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // Monitor: compare each queued item 2 ns after the rising edge it belongs to.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check_one(e.tag, "rdata",   flag_rdata, e.rd);
            check_one(e.tag, "pending", pending,    e.pend);
            check_one(e.tag, "halted",  halted,     e.halt);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #100000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      //     tag            rd     pend   h  now    dfr    steps   fwr fdat   ewr edat   hlt
      drive("R1 reset",     8'hE0, 5'h00, 0, 5'h00, 5'h00, 3'b000, 0, 8'h00, 0, 8'h00, 0);
      drive("R2 enable",    8'hE0, 5'h00, 0, 5'h00, 5'h00, 3'b000, 0, 8'h00, 1, 8'hFF, 0);
      drive("R2 now",       8'hE1, 5'h01, 0, 5'h01, 5'h00, 3'b000, 0, 8'h00, 0, 8'h00, 0);
      drive("R6 write0",    8'hE0, 5'h00, 0, 5'h00, 5'h00, 3'b000, 1, 8'h00, 0, 8'h00, 0);
      drive("R2 en02",      8'hE0, 5'h00, 0, 5'h00, 5'h00, 3'b000, 0, 8'h00, 1, 8'h02, 0);
      drive("R2 mask",      8'hFF, 5'h02, 0, 5'h00, 5'h00, 3'b000, 1, 8'h1F, 0, 8'h00, 0);
      drive("R3 upper",     8'hE0, 5'h00, 0, 5'h00, 5'h00, 3'b000, 1, 8'hE0, 0, 8'h00, 0);
      drive("R3 defer",     8'hE8, 5'h00, 0, 5'h00, 5'h08, 3'b000, 0, 8'h00, 0, 8'h00, 0);
      drive("R7 running",   8'hE8, 5'h08, 0, 5'h00, 5'h00, 3'b000, 0, 8'h00, 1, 8'h08, 0);
      drive("R6 discard",   8'hE0, 5'h00, 0, 5'h00, 5'h00, 3'b000, 1, 8'h00, 0, 8'h00, 0);
      drive("R6 new keep",  8'hE8, 5'h08, 0, 5'h00, 5'h08, 3'b000, 1, 8'h00, 0, 8'h00, 0);
      drive("R6 clear",     8'hE0, 5'h00, 0, 5'h00, 5'h00, 3'b000, 1, 8'h00, 1, 8'h1F, 0);
      drive("R8 halt",      8'hE0, 5'h00, 1, 5'h00, 5'h00, 3'b000, 0, 8'h00, 0, 8'h00, 1);
      drive("R7 halted",    8'hE4, 5'h00, 1, 5'h00, 5'h04, 3'b000, 0, 8'h00, 0, 8'h00, 0);
      drive("R4 disp t",    8'hE4, 5'h00, 1, 5'h00, 5'h00, 3'b100, 0, 8'h00, 0, 8'h00, 0);
      drive("R4 timer",     8'hE4, 5'h04, 1, 5'h00, 5'h00, 3'b010, 0, 8'h00, 0, 8'h00, 0);
      drive("R8 wake",      8'hE4, 5'h04, 0, 5'h00, 5'h00, 3'b000, 0, 8'h00, 0, 8'h00, 0);
      drive("R6 clr2",      8'hE0, 5'h00, 0, 5'h00, 5'h00, 3'b000, 1, 8'h00, 0, 8'h00, 0);
      drive("R8 halt2",     8'hE0, 5'h00, 1, 5'h00, 5'h00, 3'b000, 0, 8'h00, 0, 8'h00, 1);
      drive("R3 hi def",    8'hF8, 5'h00, 1, 5'h00, 5'h18, 3'b000, 0, 8'h00, 0, 8'h00, 0);
      drive("R4 hi stay",   8'hF8, 5'h00, 1, 5'h00, 5'h00, 3'b110, 0, 8'h00, 0, 8'h00, 0);
      drive("R5 cpu",       8'hF8, 5'h18, 1, 5'h00, 5'h00, 3'b001, 0, 8'h00, 0, 8'h00, 0);
      drive("R5 wake",      8'hF8, 5'h18, 0, 5'h00, 5'h00, 3'b000, 0, 8'h00, 0, 8'h00, 0);
      drive("R6 clr3",      8'hE0, 5'h00, 0, 5'h00, 5'h00, 3'b000, 1, 8'h00, 0, 8'h00, 0);
      drive("R8 halt3",     8'hE0, 5'h00, 1, 5'h00, 5'h00, 3'b000, 0, 8'h00, 0, 8'h00, 1);
      drive("R4 same step", 8'hE1, 5'h00, 1, 5'h00, 5'h01, 3'b100, 0, 8'h00, 0, 8'h00, 0);
      drive("R4 disp",      8'hE1, 5'h01, 1, 5'h00, 5'h00, 3'b100, 0, 8'h00, 0, 8'h00, 0);
      drive("R8 wake3",     8'hE1, 5'h01, 0, 5'h00, 5'h00, 3'b000, 0, 8'h00, 0, 8'h00, 0);
      drive("R9 req wins",  8'hE2, 5'h02, 0, 5'h02, 5'h00, 3'b000, 1, 8'h00, 0, 8'h00, 0);
      drive("R8 wake wins", 8'hE2, 5'h02, 0, 5'h00, 5'h00, 3'b000, 0, 8'h00, 0, 8'h00, 1);
      drive("R2 idle",      8'hE2, 5'h02, 0, 5'h00, 5'h00, 3'b000, 0, 8'h00, 0, 8'h00, 0);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule